// File: doc/BRIEF.md
# Sound-CPU Control Page Decoder

This block sits between a small sound processor's synchronous memory bus and the peripherals it controls. It decodes the sixteen control-page locations at 0x00F0 to 0x00FF of a 64 KiB address space. From those accesses it drives the timer unit, four byte-wide communication ports, an indirect index/data window into a 128-entry DSP register file, and a boot-ROM overlay that covers the top of memory. Every address outside the control page passes through to external RAM.

Read data is combinational in the access cycle. Memory, timer counter and DSP read values come in on input ports, and the block selects among them. Strobes towards the timers, the DSP and RAM are single-cycle pulses that are valid in the cycle of the access. Register state changes on the clock edge that ends a write.

Top module: `sndctl_decode`

## Requirements
- R1: After reset the ROM overlay is on, `tmr_en` is 000, the DSP index is 0 (so `dsp_addr` is 0), and all four port bytes read 0.
- R2: A write to 0x00F0 changes no state and raises no strobe. A read of 0x00F0 returns 0.
- R3: A write to 0x00F1 loads `tmr_en` from data bits 2..0, where bit i enables timer i. A read of 0x00F1 returns 0, and no write to 0x00F1 reaches RAM.
- R4: In a write to 0x00F1, data bit 4 set to 1 zeroes ports 0x00F4 and 0x00F5, and data bit 5 set to 1 zeroes ports 0x00F6 and 0x00F7. Ports whose bit is 0 keep their values.
- R5: Data bit 7 of a write to 0x00F1 sets the overlay state: 1 turns it on and 0 turns it off.
- R6: 0x00F2 is a read/write index byte. `dsp_addr` always equals its low 7 bits.
- R7: A write to 0x00F3 pulses `dsp_we` with `dsp_wdata` equal to the written byte, but only when bit 7 of the index is 0. When that bit is 1 the write is dropped.
- R8: A read of 0x00F3 pulses `dsp_re` and returns `dsp_rdata`.
- R9: Writes to 0x00F4..0x00F7 are latched per location, and reads return the latched byte.
- R10: 0x00F8 and 0x00F9 behave as RAM: a write pulses `ram_we` and a read returns `ram_rdata`.
- R11: A write to 0x00FA+i (i = 0..2) pulses `tmr_period_wr[i]`. These locations read as 0.
- R12: A read of 0x00FD+i returns {4'b0, `tmr_cnt[4i+3:4i]`} and pulses `tmr_cnt_clr[i]`. A write to 0x00FD+i also pulses `tmr_cnt_clr[i]`.
- R13: Reads of 0xFFC0..0xFFFF return `rom_rdata` with `rom_re` high while the overlay is on, and `ram_rdata` while it is off. Writes to that range always pulse `ram_we`.
- R14: Any address outside the control page passes through: a write pulses `ram_we` and a read returns `ram_rdata`. `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| ram_we | output | 1 | Write enable to RAM |
| ram_rdata | input | 8 | RAM read data at `bus_addr` |
| rom_re | output | 1 | Read served by the boot ROM |
| rom_rdata | input | 8 | Boot-ROM read data at `bus_addr` |
| tmr_en | output | 3 | Per-timer enable levels |
| tmr_period_wr | output | 3 | Per-timer period load pulse, data on `bus_wdata` |
| tmr_cnt_clr | output | 3 | Per-timer counter clear pulse |
| tmr_cnt | input | 12 | Three 4-bit timer counter values, timer i at bits 4i+3:4i |
| dsp_addr | output | 7 | DSP register index |
| dsp_wdata | output | 8 | DSP write data |
| dsp_we | output | 1 | DSP register write pulse |
| dsp_re | output | 1 | DSP register read pulse |
| dsp_rdata | input | 8 | DSP register read data |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 64-byte ROM window (ROM_AW = 6). With those values the bench can reach both the exact overlay boundary at 0xFFBF/0xFFC0 and every control-page offset. Each stimulus input is a distinct function of the address or is held at a fixed pattern. A read that returns the wrong source, or the wrong nibble of the counter bus, therefore shows up as a data mismatch against the reference model.

// File: rtl/sndctl_decode.sv
module sndctl_decode #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata,
  output logic              rom_re,
  input  logic [7:0]        rom_rdata,
  output logic [2:0]        tmr_en,
  output logic [2:0]        tmr_period_wr,
  output logic [2:0]        tmr_cnt_clr,
  input  logic [11:0]       tmr_cnt,
  output logic [6:0]        dsp_addr,
  output logic [7:0]        dsp_wdata,
  output logic              dsp_we,
  output logic              dsp_re,
  input  logic [7:0]        dsp_rdata
);
  localparam logic [ADDR_W-5:0] PAGE_TAG = (ADDR_W-4)'(4'hF);

  logic [7:0] port_q [4];
  logic [7:0] idx_q;
  logic       rom_en_q;
  logic [2:0] en_q;

  logic       ctl;
  logic       top;
  logic [3:0] lo;

  assign ctl = bus_addr[ADDR_W-1:4] == PAGE_TAG;
  assign top = &bus_addr[ADDR_W-1:ROM_AW];
  assign lo  = bus_addr[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 3'b000;
      rom_en_q <= 1'b1;
      idx_q    <= 8'h00;
      for (int i = 0; i < 4; i++) port_q[i] <= 8'h00;
    end else if (bus_wr && ctl) begin
      case (lo)
        4'h1: begin
          en_q     <= bus_wdata[2:0];
          rom_en_q <= bus_wdata[7];
          if (bus_wdata[4]) begin
            port_q[0] <= 8'h00;
            port_q[1] <= 8'h00;
          end
          if (bus_wdata[5]) begin
            port_q[2] <= 8'h00;
            port_q[3] <= 8'h00;
          end
        end
        4'h2: idx_q <= bus_wdata;
        4'h4, 4'h5, 4'h6, 4'h7: port_q[lo[1:0]] <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign tmr_en    = en_q;
  assign dsp_addr  = idx_q[6:0];
  assign dsp_wdata = bus_wdata;
  assign dsp_we    = bus_wr && ctl && lo == 4'h3 && !idx_q[7];
  assign dsp_re    = bus_rd && ctl && lo == 4'h3;
  assign ram_we    = bus_wr && (!ctl || lo == 4'h8 || lo == 4'h9);
  assign rom_re    = bus_rd && top && rom_en_q;

  for (genvar i = 0; i < 3; i++) begin : g_tmr
    assign tmr_period_wr[i] = bus_wr && ctl && lo == 4'(10 + i);
    assign tmr_cnt_clr[i]   = (bus_rd || bus_wr) && ctl && lo == 4'(13 + i);
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (ctl) begin
        case (lo)
          4'h2: bus_rdata = idx_q;
          4'h3: bus_rdata = dsp_rdata;
          4'h4, 4'h5, 4'h6, 4'h7: bus_rdata = port_q[lo[1:0]];
          4'h8, 4'h9: bus_rdata = ram_rdata;
          4'hD: bus_rdata = {4'h0, tmr_cnt[3:0]};
          4'hE: bus_rdata = {4'h0, tmr_cnt[7:4]};
          4'hF: bus_rdata = {4'h0, tmr_cnt[11:8]};
          default: bus_rdata = 8'h00;
        endcase
      end else if (rom_re) begin
        bus_rdata = rom_rdata;
      end else begin
        bus_rdata = ram_rdata;
      end
    end
  end
endmodule

// File: rtl/sndctl_decode_chk.sv
module sndctl_decode_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              ram_we,
  input logic              rom_re,
  input logic [2:0]        tmr_en,
  input logic [2:0]        tmr_cnt_clr,
  input logic [6:0]        dsp_addr,
  input logic              dsp_we,
  input logic              rom_en_q,
  input logic [7:0]        idx_q
);
  // R3
  tmr_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16'h00F1)) |=> tmr_en == $past(bus_wdata[2:0]));

  // R5
  overlay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16'h00F1)) |=> rom_en_q == $past(bus_wdata[7]));

  // R2
  test_reg_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16'h00F0)) |=>
      (tmr_en == $past(tmr_en) && rom_en_q == $past(rom_en_q) && idx_q == $past(idx_q)));

  // R7
  dsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16'h00F3) && idx_q[7]) |-> !dsp_we);

  // R12
  cnt_clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_cnt_clr));

  // R14
  ram_we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> bus_wr);

  // R13
  rom_re_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |-> (bus_rd && rom_en_q));

  // R6
  dsp_addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16'h00F2)) |=> dsp_addr == $past(bus_wdata[6:0]));
endmodule

bind sndctl_decode sndctl_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .ram_we(ram_we), .rom_re(rom_re),
  .tmr_en(tmr_en), .tmr_cnt_clr(tmr_cnt_clr), .dsp_addr(dsp_addr),
  .dsp_we(dsp_we), .rom_en_q(rom_en_q), .idx_q(idx_q)
);

// File: tb/tb_sndctl_decode.sv
`timescale 1ns/1ps
module tb_sndctl_decode;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_rdata;
  logic        ram_we, rom_re, dsp_we, dsp_re;
  logic [7:0]  ram_rdata, rom_rdata, dsp_rdata, dsp_wdata;
  logic [2:0]  tmr_en, tmr_period_wr, tmr_cnt_clr;
  logic [11:0] tmr_cnt = 12'hA53;
  logic [6:0]  dsp_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_en, m_rom, m_idx;
  int m_port [4];

  always #5 clk = ~clk;

  assign ram_rdata = bus_addr[7:0] ^ 8'h5A;
  assign rom_rdata = ~bus_addr[7:0];
  assign dsp_rdata = {1'b1, dsp_addr} ^ 8'h3C;

  sndctl_decode dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .rom_re(rom_re), .rom_rdata(rom_rdata),
    .tmr_en(tmr_en), .tmr_period_wr(tmr_period_wr), .tmr_cnt_clr(tmr_cnt_clr),
    .tmr_cnt(tmr_cnt), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
    .dsp_we(dsp_we), .dsp_re(dsp_re), .dsp_rdata(dsp_rdata)
  );

  function automatic int cnt_nib(int i);
    return (tmr_cnt >> (4 * i)) & 15;
  endfunction

  task automatic op(input bit rd, input bit wr, input int addr, input int d, input string req);
    bit ctl, top;
    int lo, e_rd, e_ramwe, e_romre, e_dwe, e_dre, e_pw, e_cc;
    @(negedge clk);
    bus_addr = addr[15:0]; bus_wdata = d[7:0]; bus_rd = rd; bus_wr = wr;
    #2;
    ctl = (addr >> 4) == 16'h00F;
    top = addr >= 16'hFFC0;
    lo  = addr & 15;
    e_rd = 0;
    if (rd) begin
      if (ctl) begin
        if (lo == 2) e_rd = m_idx;
        else if (lo == 3) e_rd = ((m_idx & 127) | 128) ^ 8'h3C;
        else if (lo >= 4 && lo <= 7) e_rd = m_port[lo - 4];
        else if (lo == 8 || lo == 9) e_rd = (addr & 255) ^ 8'h5A;
        else if (lo >= 13) e_rd = cnt_nib(lo - 13);
      end else if (top && m_rom != 0) e_rd = (~addr) & 255;
      else e_rd = (addr & 255) ^ 8'h5A;
    end
    e_ramwe = wr && (!ctl || lo == 8 || lo == 9);
    e_romre = rd && top && m_rom != 0;
    e_dwe   = wr && ctl && lo == 3 && m_idx < 128;
    e_dre   = rd && ctl && lo == 3;
    e_pw    = (wr && ctl && lo >= 10 && lo <= 12) ? (1 << (lo - 10)) : 0;
    e_cc    = ((rd || wr) && ctl && lo >= 13) ? (1 << (lo - 13)) : 0;
    n_chk++;
    if (bus_rdata !== e_rd[7:0] || ram_we !== e_ramwe[0] || rom_re !== e_romre[0] ||
        dsp_we !== e_dwe[0] || dsp_re !== e_dre[0] || tmr_period_wr !== e_pw[2:0] ||
        tmr_cnt_clr !== e_cc[2:0] || tmr_en !== m_en[2:0] || dsp_addr !== m_idx[6:0] ||
        (e_dwe != 0 && dsp_wdata !== d[7:0])) begin
      n_fail++;
      $display("FAIL %s addr=%h: rdata=%h/%h ramwe=%b/%0d romre=%b/%0d dwe=%b/%0d dre=%b/%0d pw=%b/%0d cc=%b/%0d en=%b/%0d daddr=%h/%h",
        req, addr[15:0], bus_rdata, e_rd[7:0], ram_we, e_ramwe, rom_re, e_romre,
        dsp_we, e_dwe, dsp_re, e_dre, tmr_period_wr, e_pw, tmr_cnt_clr, e_cc,
        tmr_en, m_en, dsp_addr, m_idx[6:0]);
    end
    @(posedge clk);
    if (wr && ctl) begin
      if (lo == 1) begin
        m_en = d & 7; m_rom = (d >> 7) & 1;
        if (d & 16) begin m_port[0] = 0; m_port[1] = 0; end
        if (d & 32) begin m_port[2] = 0; m_port[3] = 0; end
      end else if (lo == 2) m_idx = d & 255;
      else if (lo >= 4 && lo <= 7) m_port[lo - 4] = d & 255;
    end
  endtask

  initial begin
    m_en = 0; m_rom = 1; m_idx = 0;
    for (int i = 0; i < 4; i++) m_port[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    op(0, 0, 16'h0000, 0, "R1");
    op(1, 0, 16'h00F4, 0, "R1");
    op(1, 0, 16'h00F7, 0, "R1");
    op(1, 0, 16'hFFF0, 0, "R1");
    op(0, 1, 16'h00F0, 8'hFF, "R2");
    op(1, 0, 16'h00F0, 0, "R2");
    for (int a = 4; a < 8; a++) op(0, 1, 16'h00F0 + a, 8'h11 * (a + 1), "R9");
    for (int a = 4; a < 8; a++) op(1, 0, 16'h00F0 + a, 0, "R9");
    op(0, 1, 16'h00F1, 8'h05, "R3");
    op(1, 0, 16'h00F1, 0, "R3");
    op(1, 0, 16'hFFC0, 0, "R5");
    op(1, 0, 16'hFFBF, 0, "R13");
    op(0, 1, 16'h00F1, 8'h92, "R4");
    for (int a = 4; a < 8; a++) op(1, 0, 16'h00F0 + a, 0, "R4");
    op(1, 0, 16'hFFC0, 0, "R5");
    op(1, 0, 16'hFFBF, 0, "R13");
    op(0, 1, 16'h00F6, 8'h77, "R9");
    op(0, 1, 16'h00F4, 8'h44, "R9");
    op(0, 1, 16'h00F1, 8'hA1, "R4");
    for (int a = 4; a < 8; a++) op(1, 0, 16'h00F0 + a, 0, "R4");
    op(0, 1, 16'h00F2, 8'h85, "R6");
    op(1, 0, 16'h00F2, 0, "R6");
    op(0, 1, 16'h00F3, 8'h3E, "R7");
    op(1, 0, 16'h00F3, 0, "R8");
    op(0, 1, 16'h00F2, 8'h7F, "R6");
    op(0, 1, 16'h00F3, 8'hC9, "R7");
    op(1, 0, 16'h00F3, 0, "R8");
    op(0, 1, 16'h00F8, 8'h12, "R10");
    op(1, 0, 16'h00F9, 0, "R10");
    for (int a = 10; a < 13; a++) op(0, 1, 16'h00F0 + a, 8'h40, "R11");
    for (int a = 10; a < 13; a++) op(1, 0, 16'h00F0 + a, 0, "R11");
    for (int a = 13; a < 16; a++) op(1, 0, 16'h00F0 + a, 0, "R12");
    for (int a = 13; a < 16; a++) op(0, 1, 16'h00F0 + a, 8'h09, "R12");
    op(0, 1, 16'hFFC5, 8'h66, "R13");
    op(1, 0, 16'hFFFF, 0, "R13");
    op(0, 1, 16'h0100, 8'h21, "R14");
    op(1, 0, 16'h00EF, 0, "R14");
    op(1, 0, 16'h0F0F, 0, "R14");
    op(0, 0, 16'h00F3, 0, "R14");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule